// File: doc/BRIEF.md
# Autoincrement Register Change Log

This block keeps a short history of the general registers that the current instruction has stepped by autoincrement or autodecrement. It also records the signed step applied to each of them. A fault handler reads the history after an abort, subtracts each recorded step from its register and restarts the instruction. The history empties itself whenever a new instruction fetch begins. It has room for two entries. The first entry goes into the low byte and the second into the high byte. Any later step in the same instruction is dropped.

A second register latches the virtual PC at every instruction fetch, so that the handler can reload the PC of the faulting instruction. A freeze input, raised when an abort is taken, holds both registers so that the handler sees the state of the faulting instruction. Software reads the two registers through a one-bit select and a combinational data port. Software cannot write either register.

Top module: `reg_mod_log`

## Requirements
- R1: After reset, both the change log and the captured PC read as 0.
- R2: A fetch strobe without freeze clears the log to 0 and loads `fetch_pc` into the PC register, both visible from the next cycle.
- R3: The first modify strobe after a fetch writes the low byte of the log: bits 2:0 take the register number (modulo 8) and bits 7:3 take the 5-bit two's complement change amount, from -16 to +15.
- R4: The second modify strobe after a fetch writes the high byte in the same layout: bits 10:8 take the register number and bits 15:11 take the amount. The low byte keeps its value.
- R5: A third or later modify strobe within one instruction is ignored, and the log keeps both entries it holds.
- R6: When a fetch strobe and a modify strobe arrive in the same cycle, the fetch wins: the log reads 0 afterwards and the modify is dropped.
- R7: While `freeze` is high, the log and the captured PC hold their values, whatever the fetch and modify strobes do.
- R8: With `rd_sel` = 0, `rd_data` shows the log. With `rd_sel` = 1, it shows the captured PC. The read is combinational, in the same cycle.
- R9: Modify strobes never change the captured PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_start | input | 1 | Start of an instruction fetch |
| fetch_pc | input | 16 | Virtual PC of the instruction being fetched |
| mod_valid | input | 1 | A general register was autoincremented or autodecremented |
| mod_reg | input | 3 | Number of the modified register |
| mod_amount | input | 5 | Signed change amount, two's complement |
| freeze | input | 1 | Hold both registers (abort in progress) |
| rd_sel | input | 1 | Read select: 0 for the log, 1 for the captured PC |
| rd_data | output | 16 | Read data |

## Verification
On every cycle, the assertions check the following:
- the fill count stays within two entries;
- a fetch clears the log and captures the PC;
- a freeze holds both registers;
- a strobe that arrives on a full log leaves the log unchanged;
- a modify strobe leaves the PC unchanged.

Only the bench's scenarios can show the content of each entry: which byte is filled, whether the register number and signed amount sit at the right bit positions, and how the amounts at the ends of the range (-16 and +15) come out. The scenarios also show the fetch-over-modify priority and the values presented on the read port.

// File: rtl/rml_pkg.sv
package rml_pkg;
   // Read port selection codes
   typedef enum logic {
      RML_SEL_LOG = 1'b0,
      RML_SEL_PC  = 1'b1
   } rml_sel_e;

   function automatic int rml_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/rml_entry_log.sv
module rml_entry_log #(
   parameter int REG_W = 3,
   parameter int AMT_W = 5,
   parameter int SLOTS = 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             freeze,
   input  logic                             clear,
   input  logic                             mod_valid,
   input  logic [REG_W-1:0]                 mod_reg,
   input  logic [AMT_W-1:0]                 mod_amount,
   output logic [(REG_W+AMT_W)*SLOTS-1:0]   log_q
);
   localparam int ENT_W = REG_W + AMT_W;
   localparam int CNT_W = $clog2(SLOTS + 1);

   generate
      if (SLOTS < 1) begin : g_bad_slots
         $error("rml_entry_log: SLOTS must be at least 1");
      end
      if (AMT_W < 2) begin : g_bad_amt
         $error("rml_entry_log: AMT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] fill_q;
   logic             has_room;
   logic             accept;

   assign has_room = (fill_q < CNT_W'(SLOTS));
   assign accept   = mod_valid && !clear && !freeze && has_room;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q <= '0;
      end else if (!freeze) begin
         if (clear)       fill_q <= '0;
         else if (accept) fill_q <= fill_q + 1'b1;
      end
   end

   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
         logic [ENT_W-1:0] ent_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ent_q <= '0;
            end else if (!freeze) begin
               if (clear)
                  ent_q <= '0;
               else if (accept && fill_q == CNT_W'(s))
                  ent_q <= {mod_amount, mod_reg};
            end
         end
         assign log_q[s*ENT_W +: ENT_W] = ent_q;
      end
   endgenerate

   // R5
   fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_q <= CNT_W'(SLOTS));

   // R2
   clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !freeze) |=> (log_q == '0));

   // R7
   freeze_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |=> $stable(log_q));

   // R5
   full_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!has_room && mod_valid && !clear && !freeze) |=> $stable(log_q));
endmodule

// File: rtl/rml_pc_capture.sv
module rml_pc_capture #(
   parameter int PC_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            freeze,
   input  logic            capture,
   input  logic            mod_valid,
   input  logic [PC_W-1:0] pc_in,
   output logic [PC_W-1:0] pc_q
);
   generate
      if (PC_W < 1) begin : g_bad_pc
         $error("rml_pc_capture: PC_W must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  pc_q <= '0;
      else if (capture && !freeze) pc_q <= pc_in;
   end

   // R2
   pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && !freeze) |=> (pc_q == $past(pc_in)));

   // R7
   freeze_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |=> $stable(pc_q));

   // R9
   mod_keeps_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_valid && !capture) |=> $stable(pc_q));
endmodule

// File: rtl/rml_read_mux.sv
module rml_read_mux
   import rml_pkg::*;
#(
   parameter int LOG_W  = 16,
   parameter int PC_W   = 16,
   parameter int DATA_W = 16
) (
   input  logic              sel,
   input  logic [LOG_W-1:0]  log_val,
   input  logic [PC_W-1:0]   pc_val,
   output logic [DATA_W-1:0] rd_data
);
   generate
      if (DATA_W < LOG_W || DATA_W < PC_W) begin : g_bad_data
         $error("rml_read_mux: DATA_W narrower than a source");
      end
   endgenerate

   always_comb begin
      if (rml_sel_e'(sel) == RML_SEL_PC) rd_data = DATA_W'(pc_val);
      else                               rd_data = DATA_W'(log_val);
   end
endmodule

// File: rtl/reg_mod_log.sv
module reg_mod_log
   import rml_pkg::*;
#(
   parameter int REG_W = 3,
   parameter int AMT_W = 5,
   parameter int SLOTS = 2,
   parameter int PC_W  = 16,
   localparam int LOG_W  = (REG_W + AMT_W) * SLOTS,
   localparam int DATA_W = rml_max(LOG_W, PC_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_start,
   input  logic [PC_W-1:0]   fetch_pc,
   input  logic              mod_valid,
   input  logic [REG_W-1:0]  mod_reg,
   input  logic [AMT_W-1:0]  mod_amount,
   input  logic              freeze,
   input  logic              rd_sel,
   output logic [DATA_W-1:0] rd_data
);
   logic [LOG_W-1:0] log_w;
   logic [PC_W-1:0]  pc_w;

   rml_entry_log #(.REG_W(REG_W), .AMT_W(AMT_W), .SLOTS(SLOTS)) u_log (
      .clk        (clk),
      .rst_n      (rst_n),
      .freeze     (freeze),
      .clear      (fetch_start),
      .mod_valid  (mod_valid),
      .mod_reg    (mod_reg),
      .mod_amount (mod_amount),
      .log_q      (log_w)
   );

   rml_pc_capture #(.PC_W(PC_W)) u_pc (
      .clk       (clk),
      .rst_n     (rst_n),
      .freeze    (freeze),
      .capture   (fetch_start),
      .mod_valid (mod_valid),
      .pc_in     (fetch_pc),
      .pc_q      (pc_w)
   );

   rml_read_mux #(.LOG_W(LOG_W), .PC_W(PC_W), .DATA_W(DATA_W)) u_rd (
      .sel     (rd_sel),
      .log_val (log_w),
      .pc_val  (pc_w),
      .rd_data (rd_data)
   );
endmodule

// File: tb/reg_mod_log_bench.sv
`timescale 1ns/1ps
module reg_mod_log_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_start = 1'b0;
   logic [15:0] fetch_pc = '0;
   logic        mod_valid = 1'b0;
   logic [2:0]  mod_reg = '0;
   logic [4:0]  mod_amount = '0;
   logic        freeze = 1'b0;
   logic        rd_sel = 1'b0;
   logic [15:0] rd_data;

   int compared = 0;
   int mismatched = 0;

   // behavioural model state
   logic [7:0]  m_ent[$];
   logic [15:0] m_pc = '0;

   always #2.5 clk = ~clk;

   reg_mod_log u_reg_mod_log (
      .clk(clk), .rst_n(rst_n), .fetch_start(fetch_start), .fetch_pc(fetch_pc),
      .mod_valid(mod_valid), .mod_reg(mod_reg), .mod_amount(mod_amount),
      .freeze(freeze), .rd_sel(rd_sel), .rd_data(rd_data)
   );

   function automatic logic [15:0] model_log();
      logic [15:0] v = '0;
      foreach (m_ent[i]) v[i*8 +: 8] = m_ent[i];
      return v;
   endfunction

   task automatic compare(input string tag);
      logic [15:0] exp_log = model_log();
      rd_sel = 1'b0; #0.5;
      compared++;
      if (rd_data !== exp_log) begin
         mismatched++;
         $display("FAIL %s log: actual %h expected %h", tag, rd_data, exp_log);
      end
      rd_sel = 1'b1; #0.5;
      compared++;
      if (rd_data !== m_pc) begin
         mismatched++;
         $display("FAIL %s pc: actual %h expected %h", tag, rd_data, m_pc);
      end
   endtask

   // drive at negedge, model at posedge, compare shortly after posedge
   task automatic step(input logic f, input logic [15:0] pc, input logic m,
                       input logic [2:0] r, input logic [4:0] a,
                       input logic fz, input string tag);
      @(negedge clk);
      fetch_start = f; fetch_pc = pc; mod_valid = m;
      mod_reg = r; mod_amount = a; freeze = fz;
      @(posedge clk);
      if (!fz) begin
         if (f) begin
            m_ent.delete();
            m_pc = pc;
         end else if (m && m_ent.size() < 2) begin
            m_ent.push_back({a, r});
         end
      end
      #0.5;
      compare(tag);
   endtask

   initial begin
      #(200000 * 5);
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      #12;
      compare("R1");
      @(negedge clk); rst_n = 1'b1;
      step(0, 16'h0, 0, 3'd0, 5'd0, 0, "R1");
      // R2: fetch captures PC, clears log
      step(1, 16'h1234, 0, 3'd0, 5'd0, 0, "R2");
      // R3: low byte first, +2 on register 2
      step(0, 16'hFFFF, 1, 3'd2, 5'd2, 0, "R3_R9");
      // R4: high byte, -2 on register 7 (PC)
      step(0, 16'hFFFF, 1, 3'd7, 5'b11110, 0, "R4_R9");
      // R5: third strobe dropped
      step(0, 16'h0, 1, 3'd1, 5'd4, 0, "R5");
      step(0, 16'h0, 1, 3'd3, 5'd1, 0, "R5");
      // R6: fetch and modify together
      step(1, 16'h0100, 1, 3'd5, 5'd1, 0, "R6");
      // R3 amount boundaries
      step(0, 16'h0, 1, 3'd6, 5'b10000, 0, "R3");
      step(0, 16'h0, 1, 3'd4, 5'b01111, 0, "R4");
      // R7: freeze holds through fetch and modify
      step(1, 16'hBEEF, 1, 3'd1, 5'd1, 1, "R7");
      step(0, 16'h0, 1, 3'd1, 5'd1, 1, "R7");
      step(0, 16'h0, 0, 3'd0, 5'd0, 0, "R7");
      // R2 again with a partial log
      step(1, 16'h2000, 0, 3'd0, 5'd0, 0, "R2");
      step(0, 16'h0, 1, 3'd0, 5'b11111, 0, "R3");
      step(1, 16'h2002, 0, 3'd0, 5'd0, 0, "R2");
      // R8: both selections observed in every compare above
      step(0, 16'h0, 1, 3'd7, 5'd2, 0, "R8");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule